// File: doc/BRIEF.md
# Level/Edge Selectable Interrupt Pending Controller

This block gathers interrupt requests from on-chip peripherals and from a small group of active-low external request pins into 32-bit pending banks. Each pending bank has a mask bank beside it. A single CPU interrupt line is raised whenever any pending bit in an active bank is also enabled by its mask bit. Internal request bits only follow their source. Each external pin has its own sensitivity bit. With that bit clear, the pin's pending bit follows the synchronized pin level. With that bit set, a falling edge on the pin latches the pending bit, and software clears it by writing a one to it.

After reset the controller is in compatible mode, where only bank 0 is visible. A mode register selects extended mode, which enables the further pending banks, their mask banks and their read-only status words. A read-only vector register gives the index of the lowest-numbered pending and unmasked bit. Software uses that index to find which source to service. All registers sit on a simple single-cycle register bus. Reads are combinational.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, every mask bit reads 0 and every sensitivity bit reads 0 (level). The mode word reads 0 (compatible). `cpu_irq` is 0 and the vector register reads all ones (127 with the defaults).
- R2: The flat pending bit at index N_EXT+j follows `int_req[j]`. Writes to a pending register never change it.
- R3: With its sensitivity bit 0, pending bit i of bank 0 equals the inverted pin `irq_n_pin[i]` after a two-flop synchronizer. A write of 1 to that bit has no effect.
- R4: With its sensitivity bit 1, a falling edge on pin i sets pending bit i of bank 0. The bit stays set after the pin returns high.
- R5: Writing bank-0 pending (address 0) with bit i = 1 clears an edge-latched bit i. Writing 0 at bit i leaves it unchanged.
- R6: When a falling edge and a one-write clear of the same edge bit meet in the same cycle, the bit remains set.
- R7: `cpu_irq` is the OR over all active banks of pending AND mask. The bank-0 mask sits at address 1, sensitivity at address 2 (bits N_EXT-1:0, 1 = edge), and mode at address 3 (bit 0, 1 = extended).
- R8: In compatible mode, reads of addresses 5 and above return 0 and writes to extra mask registers are ignored. Banks 1 and up do not reach `cpu_irq` or the vector.
- R9: In extended mode, bank b ≥ 1 has its pending word at 5+3(b-1), its mask at the next address, and a status word (pending AND mask) after that.
- R10: The vector register (address 4) returns the lowest flat index among active pending-and-unmasked bits, or all ones when there are none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| int_req | input | N_BANK*DATA_W-N_EXT | Internal peripheral requests, active high |
| irq_n_pin | input | N_EXT | External requests, active low |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
An internal request is raised and dropped around a write of all ones to its pending register. This separates a live-tracking bit from a latched one. One external pin is held low in level mode and in edge mode, then released. Only the edge-mode bit may survive the release, and only there may a one-write clear it. A one-write lands exactly in the cycle a new falling edge is detected, which shows the edge wins over the clear. Two requests with different indices are masked in and out to check the lowest-index vector. The same upper-bank request is tried in both modes, which shows the extra banks are hidden and locked in compatible mode.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

   localparam int unsigned ADR_PEND0 = 0;
   localparam int unsigned ADR_MASK0 = 1;
   localparam int unsigned ADR_SENSE = 2;
   localparam int unsigned ADR_MODE  = 3;
   localparam int unsigned ADR_VECT  = 4;
   localparam int unsigned ADR_XBASE = 5;
   localparam int unsigned XSTRIDE   = 3;

   typedef enum logic {
      MODE_COMPAT = 1'b0,
      MODE_EXT    = 1'b1
   } irq_mode_e;

   // Address of the pending word of an extra bank (b >= 1)
   function automatic int unsigned xpend_adr(input int unsigned b);
      return ADR_XBASE + XSTRIDE * (b - 1);
   endfunction

   function automatic int unsigned mask_adr(input int unsigned b);
      return (b == 0) ? ADR_MASK0 : xpend_adr(b) + 1;
   endfunction

   function automatic int unsigned xstat_adr(input int unsigned b);
      return xpend_adr(b) + 2;
   endfunction

endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync #(
   parameter int unsigned N_PIN      = 8,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PIN-1:0] pin_n,
   input  logic [N_PIN-1:0] sense,
   input  logic [N_PIN-1:0] w1c,
   output logic [N_PIN-1:0] lvl,
   output logic [N_PIN-1:0] fall,
   output logic [N_PIN-1:0] pend
);

   if (SYNC_DEPTH < 2) begin : g_bad_depth
      $error("irq_ext_sync: SYNC_DEPTH must be at least 2");
   end

   for (genvar i = 0; i < N_PIN; i++) begin : g_pin
      logic [SYNC_DEPTH-1:0] sh;
      logic                  prev_q;
      logic                  latch_q;
      logic                  cur;

      assign cur = sh[SYNC_DEPTH-1];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh      <= '1;
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
         end else begin
            sh      <= {sh[SYNC_DEPTH-2:0], pin_n[i]};
            prev_q  <= cur;
            latch_q <= sense[i] & (fall[i] | (latch_q & ~w1c[i]));
         end
      end

      assign lvl[i]  = ~cur;
      assign fall[i] = prev_q & ~cur;
      assign pend[i] = sense[i] ? latch_q : ~cur;
   end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned N_BANK = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_BANK-1:0]        we,
   input  logic [DATA_W-1:0]        wdata,
   output logic [N_BANK*DATA_W-1:0] mask
);

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      logic [DATA_W-1:0] m_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     m_q <= '0;
         else if (we[b]) m_q <= wdata;
      end
      assign mask[b*DATA_W +: DATA_W] = m_q;
   end

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int unsigned WIDTH = 96,
   parameter int unsigned IDX_W = 7
) (
   input  logic [WIDTH-1:0] vec,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   if ((1 << IDX_W) <= WIDTH) begin : g_bad_idx
      $error("irq_first_set: IDX_W too small for an all-ones empty code");
   end

   always_comb begin
      idx = '1;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign hit = |vec;

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
   import irq_pend_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned N_BANK     = 3,
   parameter int unsigned N_EXT      = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_sel,
   input  logic                            bus_wr,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [DATA_W-1:0]               bus_wdata,
   output logic [DATA_W-1:0]               bus_rdata,
   input  logic [N_BANK*DATA_W-N_EXT-1:0]  int_req,
   input  logic [N_EXT-1:0]                irq_n_pin,
   output logic                            cpu_irq
);

   localparam int unsigned TOT   = N_BANK * DATA_W;
   localparam int unsigned IDX_W = $clog2(TOT + 1);
   localparam int unsigned TOP_A = ADR_XBASE + XSTRIDE * (N_BANK - 1);

   if (N_EXT == 0 || N_EXT > DATA_W) begin : g_bad_ext
      $error("irq_pend_ctrl: N_EXT must be within 1..DATA_W");
   end
   if (N_BANK == 0 || TOP_A > (1 << ADDR_W)) begin : g_bad_map
      $error("irq_pend_ctrl: register map does not fit ADDR_W");
   end
   if (IDX_W > DATA_W) begin : g_bad_vw
      $error("irq_pend_ctrl: vector index wider than data word");
   end

   logic [31:0]       adr32;
   logic              wr_cyc;
   logic [N_EXT-1:0]  sense_q;
   irq_mode_e         mode_q;
   logic              mode_ext;
   logic [N_EXT-1:0]  ext_w1c;
   logic [N_EXT-1:0]  ext_lvl;
   logic [N_EXT-1:0]  ext_fall;
   logic [N_EXT-1:0]  ext_pend;
   logic [TOT-1:0]    pend_flat;
   logic [TOT-1:0]    mask_flat;
   logic [TOT-1:0]    bank_on;
   logic [TOT-1:0]    eff;
   logic [N_BANK-1:0] mask_we;
   logic              hit;
   logic [IDX_W-1:0]  vec_idx;

   assign adr32    = 32'(bus_addr);
   assign wr_cyc   = bus_sel & bus_wr;
   assign mode_ext = (mode_q == MODE_EXT);
   assign ext_w1c  = (wr_cyc && adr32 == ADR_PEND0) ? bus_wdata[N_EXT-1:0] : '0;

   // Configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         mode_q  <= MODE_COMPAT;
      end else if (wr_cyc) begin
         if (adr32 == ADR_SENSE) sense_q <= bus_wdata[N_EXT-1:0];
         if (adr32 == ADR_MODE)  mode_q  <= irq_mode_e'(bus_wdata[0]);
      end
   end

   irq_ext_sync #(
      .N_PIN      (N_EXT),
      .SYNC_DEPTH (SYNC_DEPTH)
   ) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (irq_n_pin),
      .sense (sense_q),
      .w1c   (ext_w1c),
      .lvl   (ext_lvl),
      .fall  (ext_fall),
      .pend  (ext_pend)
   );

   assign pend_flat = {int_req, ext_pend};

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      assign mask_we[b] = wr_cyc && (adr32 == mask_adr(b)) && ((b == 0) || mode_ext);
      assign bank_on[b*DATA_W +: DATA_W] = {DATA_W{(b == 0) || mode_ext}};
   end

   irq_mask_bank #(
      .N_BANK (N_BANK),
      .DATA_W (DATA_W)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we),
      .wdata (bus_wdata),
      .mask  (mask_flat)
   );

   assign eff = pend_flat & mask_flat & bank_on;

   irq_first_set #(
      .WIDTH (TOT),
      .IDX_W (IDX_W)
   ) u_first (
      .vec (eff),
      .hit (hit),
      .idx (vec_idx)
   );

   assign cpu_irq = |eff;

   // Read path
   always_comb begin
      bus_rdata = '0;
      if (adr32 == ADR_PEND0)      bus_rdata = pend_flat[DATA_W-1:0];
      else if (adr32 == ADR_MASK0) bus_rdata = mask_flat[DATA_W-1:0];
      else if (adr32 == ADR_SENSE) bus_rdata[N_EXT-1:0] = sense_q;
      else if (adr32 == ADR_MODE)  bus_rdata[0] = mode_ext;
      else if (adr32 == ADR_VECT)  bus_rdata[IDX_W-1:0] = vec_idx;
      else if (mode_ext) begin
         for (int unsigned b = 1; b < N_BANK; b++) begin
            if (adr32 == xpend_adr(b)) bus_rdata = pend_flat[b*DATA_W +: DATA_W];
            if (adr32 == mask_adr(b))  bus_rdata = mask_flat[b*DATA_W +: DATA_W];
            if (adr32 == xstat_adr(b)) bus_rdata = eff[b*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
   import irq_pend_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_BANK = 3,
   parameter int unsigned N_EXT  = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned IDX_W  = 7
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_sel,
   input logic                      bus_wr,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [DATA_W-1:0]         bus_wdata,
   input logic [DATA_W-1:0]         bus_rdata,
   input logic                      cpu_irq,
   input logic [N_EXT-1:0]          sense_q,
   input logic [N_EXT-1:0]          ext_lvl,
   input logic [N_EXT-1:0]          ext_fall,
   input logic [N_EXT-1:0]          ext_pend,
   input logic [N_BANK*DATA_W-1:0]  mask_flat,
   input logic                      mode_ext,
   input logic                      hit,
   input logic [IDX_W-1:0]          vec_idx
);

   logic [31:0] a32;
   assign a32 = 32'(bus_addr);

   for (genvar i = 0; i < N_EXT; i++) begin : g_pin
      logic touch;
      assign touch = bus_sel && bus_wr &&
                     ((a32 == ADR_PEND0 && bus_wdata[i]) || a32 == ADR_SENSE);

      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
         !sense_q[i] |-> (ext_pend[i] == ext_lvl[i]));                 // R3
      AST_EDGE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
         (sense_q[i] && ext_fall[i] && !(bus_sel && bus_wr && a32 == ADR_SENSE))
            |=> ext_pend[i]);                                          // R6
      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (sense_q[i] && ext_pend[i] && !touch) |=> ext_pend[i]);        // R5
   end

   AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ext && mask_flat[DATA_W-1:0] == '0) |-> !cpu_irq);         // R7
   AST_COMPAT_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ext && bus_sel && !bus_wr && a32 >= ADR_XBASE) |-> (bus_rdata == '0)); // R8
   AST_VEC_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == hit);                                                  // R10
   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (32'(vec_idx) < N_BANK * DATA_W));                        // R10
   AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (vec_idx == '1));                                        // R10

endmodule

bind irq_pend_ctrl irq_pend_chk #(
   .DATA_W (DATA_W),
   .N_BANK (N_BANK),
   .N_EXT  (N_EXT),
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cpu_irq   (cpu_irq),
   .sense_q   (sense_q),
   .ext_lvl   (ext_lvl),
   .ext_fall  (ext_fall),
   .ext_pend  (ext_pend),
   .mask_flat (mask_flat),
   .mode_ext  (mode_ext),
   .hit       (hit),
   .vec_idx   (vec_idx)
);

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;

   localparam int unsigned DW  = 32;
   localparam int unsigned NB  = 3;
   localparam int unsigned NE  = 8;
   localparam int unsigned AW  = 4;
   localparam int unsigned NI  = NB * DW - NE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NI-1:0] ireq = '0;
   logic [NE-1:0] pin_n = '1;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_pend_ctrl #(
      .DATA_W (DW), .N_BANK (NB), .N_EXT (NE), .ADDR_W (AW), .SYNC_DEPTH (2)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .bus_sel (sel), .bus_wr (wr),
      .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata),
      .int_req (ireq), .irq_n_pin (pin_n), .cpu_irq (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      sel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic irq_now(output logic v);
      @(negedge clk);
      #1 v = irq;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      logic v;
      bus_read(4'd1, d);  chk("R1 mask0", d, 32'h0);
      bus_read(4'd2, d);  chk("R1 sense", d, 32'h0);
      bus_read(4'd3, d);  chk("R1 mode", d, 32'h0);
      bus_read(4'd4, d);  chk("R1 vector", d, 32'd127);
      irq_now(v);         chk("R1 irq", 32'(v), 32'h0);
   endtask

   task automatic t_internal;
      logic [31:0] d;
      @(negedge clk) ireq[3] = 1'b1;
      bus_read(4'd0, d);  chk("R2 live set", d, 32'h0000_0800);
      bus_write(4'd0, 32'hFFFF_FFFF);
      bus_read(4'd0, d);  chk("R2 write ignored", d, 32'h0000_0800);
      @(negedge clk) ireq[3] = 1'b0;
      bus_read(4'd0, d);  chk("R2 live clear", d, 32'h0);
   endtask

   task automatic t_level;
      logic [31:0] d;
      @(negedge clk) pin_n[2] = 1'b0;
      idle(3);
      bus_read(4'd0, d);  chk("R3 level set", d, 32'h4);
      bus_write(4'd0, 32'h4);
      bus_read(4'd0, d);  chk("R3 clear write ignored", d, 32'h4);
      @(negedge clk) pin_n[2] = 1'b1;
      idle(3);
      bus_read(4'd0, d);  chk("R3 level drop", d, 32'h0);
   endtask

   task automatic t_edge;
      logic [31:0] d;
      bus_write(4'd2, 32'h1);
      @(negedge clk) pin_n[0] = 1'b0;
      idle(4);
      bus_read(4'd0, d);  chk("R4 edge latched", d, 32'h1);
      @(negedge clk) pin_n[0] = 1'b1;
      idle(4);
      bus_read(4'd0, d);  chk("R4 held after release", d, 32'h1);
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      bus_write(4'd0, 32'hFFFF_FFFE);
      bus_read(4'd0, d);  chk("R5 zero write keeps", d, 32'h1);
      bus_write(4'd0, 32'h1);
      bus_read(4'd0, d);  chk("R5 one write clears", d, 32'h0);
   endtask

   task automatic t_race;
      logic [31:0] d;
      // latch the bit first
      @(negedge clk) pin_n[0] = 1'b0;
      idle(4);
      @(negedge clk) pin_n[0] = 1'b1;
      idle(4);
      // new falling edge detected in the same cycle as the clear write
      @(negedge clk) pin_n[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = 4'd0; wdata = 32'h1;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
      bus_read(4'd0, d);  chk("R6 edge beats clear", d, 32'h1);
      @(negedge clk) pin_n[0] = 1'b1;
      idle(3);
      bus_write(4'd0, 32'h1);
      bus_write(4'd2, 32'h0);
   endtask

   task automatic t_mask;
      logic v;
      @(negedge clk) ireq[0] = 1'b1;
      irq_now(v);         chk("R7 masked off", 32'(v), 32'h0);
      bus_write(4'd1, 32'h100);
      irq_now(v);         chk("R7 unmasked", 32'(v), 32'h1);
      bus_write(4'd1, 32'h200);
      irq_now(v);         chk("R7 other bit masked", 32'(v), 32'h0);
      bus_write(4'd1, 32'h0);
      @(negedge clk) ireq[0] = 1'b0;
   endtask

   task automatic t_vector;
      logic [31:0] d;
      @(negedge clk) begin ireq[2] = 1'b1; ireq[12] = 1'b1; end
      bus_write(4'd1, 32'h0010_0400);
      bus_read(4'd4, d);  chk("R10 lowest index", d, 32'd10);
      @(negedge clk) ireq[2] = 1'b0;
      bus_read(4'd4, d);  chk("R10 next index", d, 32'd20);
      bus_write(4'd1, 32'h0);
      bus_read(4'd4, d);  chk("R10 none pending", d, 32'd127);
      @(negedge clk) ireq[12] = 1'b0;
   endtask

   task automatic t_compat;
      logic [31:0] d;
      logic v;
      @(negedge clk) ireq[24] = 1'b1;
      bus_write(4'd6, 32'h1);
      bus_read(4'd5, d);  chk("R8 pend1 hidden", d, 32'h0);
      irq_now(v);         chk("R8 no irq", 32'(v), 32'h0);
      bus_write(4'd3, 32'h1);
      bus_read(4'd6, d);  chk("R8 mask write ignored", d, 32'h0);
   endtask

   task automatic t_extended;
      logic [31:0] d;
      logic v;
      bus_read(4'd5, d);  chk("R9 pend1 visible", d, 32'h1);
      bus_write(4'd6, 32'h1);
      bus_read(4'd6, d);  chk("R9 mask1 stored", d, 32'h1);
      bus_read(4'd7, d);  chk("R9 status1", d, 32'h1);
      irq_now(v);         chk("R9 irq from bank1", 32'(v), 32'h1);
      bus_read(4'd4, d);  chk("R10 vector bank1", d, 32'd32);
      @(negedge clk) ireq[56] = 1'b1;
      bus_read(4'd8, d);  chk("R9 pend2", d, 32'h1);
      bus_read(4'd10, d); chk("R9 status2 masked", d, 32'h0);
      bus_write(4'd3, 32'h0);
      irq_now(v);         chk("R8 bank1 off in compat", 32'(v), 32'h0);
      bus_read(4'd4, d);  chk("R8 vector ignores bank1", d, 32'd127);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_internal();
      t_level();
      t_edge();
      t_w1c();
      t_race();
      t_mask();
      t_vector();
      t_compat();
      t_extended();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule